// File: doc/BRIEF.md
# Pointer Metadata Masking Unit

This unit cleans 64-bit linear addresses before translation on a core that lets software carry metadata in the upper bits of a pointer. Each address comes with the current control state: a capability flag, two user masking enables, a supervisor masking enable, the 5-level paging flag and the long-mode flag. The most significant address bit selects the regime. A set top bit marks a supervisor pointer, which follows only the supervisor enable. A clear top bit marks a user pointer, which follows the two user enables. When masking applies, a relaxed canonicality check compares bit 63 with the chosen sign-extension bit only. If that check passes, the metadata bits are replaced by copies of that bit. If it fails, the unit raises a general-protection fault and forwards the untouched address. When masking does not apply, the ordinary full canonicality check for the current paging depth is used.

The result passes through one registered stage with a valid/ready handshake. The original address travels beside the cleaned one. A separate combinational port checks a candidate page-table-base register value for reserved bits.

Top module: `ptr_tag_strip`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An address accepted on a rising edge (`in_valid` and `in_ready` both high) appears at the outputs after that edge with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R3: User pointer (bit 63 = 0) with capability and the 57-mode enable set: if bit 56 equals bit 63, the output has bits 63:57 replaced by copies of bit 56, and bits 56:0 are unchanged.
- R4: User pointer with capability, the 48-mode enable set and the 57-mode enable clear: if bit 47 equals bit 63, the output has bits 63:48 replaced by copies of bit 47.
- R5: When both user enables are set, the 57-mode behaviour of R3 applies.
- R6: Supervisor pointer (bit 63 = 1) with capability and the supervisor enable set: the unit sign-extends from bit 56 when `la57_en` = 1 and from bit 47 when it is 0. The user enables have no effect on supervisor pointers.
- R7: When masking applies and bit 63 differs from the chosen extension bit, `out_gp` = 1 and `out_addr` equals the original address. The metadata bits themselves are never checked.
- R8: When masking does not apply to the pointer's regime, the address must be fully canonical: bits 63:47 all equal under 4-level paging, or bits 63:56 all equal under 5-level paging. A canonical address passes through unchanged with `out_gp` = 0. Any other address gives `out_gp` = 1 and the original address.
- R9: With `cap_en` = 0, all three masking enables are ignored and R8 applies.
- R10: When `lma_en` = 1, `base_chk_fault` = 1 if `base_chk_data` has any bit set at a position of PA_BITS or above. Bits 61 and 62 are exempt when `cap_en` = 1. When `lma_en` = 0, `base_chk_fault` = 0. The output is combinational.
- R11: `out_orig` always carries the accepted address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Stage can take an address |
| in_addr | input | 64 | Linear address, possibly tagged |
| cap_en | input | 1 | Masking capability present |
| u57_en | input | 1 | User 57-mode masking enable |
| u48_en | input | 1 | User 48-mode masking enable |
| sup_en | input | 1 | Supervisor masking enable |
| la57_en | input | 1 | 5-level paging active |
| lma_en | input | 1 | Long mode active |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Cleaned address, or original on fault |
| out_gp | output | 1 | General-protection fault |
| out_orig | output | 64 | Address as accepted |
| base_chk_data | input | 64 | Candidate page-table-base value |
| base_chk_fault | output | 1 | Candidate has a reserved bit set |

## Verification
The bench builds two instances. The first uses PA_BITS = 46, which puts the reserved boundary in the middle of the register: bit 45 is accepted and bit 46 faults, and bits 61 and 62 are exempt only when the capability flag is set. The second uses PA_BITS = 52, the widest setting. It shows that bit 51 is free and bit 52 is reserved. Both instances feed the same address stream. The masking path is swept over every combination of the five mode inputs, using correctly tagged, mis-tagged, canonical and non-canonical addresses.

// File: rtl/ptr_tag_strip.sv
module ptr_tag_strip #(
  parameter int PA_BITS = 46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_addr,
  input  logic        cap_en,
  input  logic        u57_en,
  input  logic        u48_en,
  input  logic        sup_en,
  input  logic        la57_en,
  input  logic        lma_en,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_addr,
  output logic        out_gp,
  output logic [63:0] out_orig,
  input  logic [63:0] base_chk_data,
  output logic        base_chk_fault
);
  localparam logic [63:0] RSV_ALL = ~64'd0 << PA_BITS;
  localparam logic [63:0] TAG_EXEMPT = 64'h3 << 61;

  logic is_sup, en57, en48, mask_on, from56, ext_bit, relaxed_ok, full_ok, gp;
  logic [63:0] sx56, sx47, clean, rsv;

  assign is_sup  = in_addr[63];
  assign en57    = cap_en & u57_en;
  assign en48    = cap_en & u48_en & ~u57_en;
  assign mask_on = is_sup ? (cap_en & sup_en) : (en57 | en48);
  assign from56  = is_sup ? la57_en : en57;
  assign ext_bit = from56 ? in_addr[56] : in_addr[47];
  assign relaxed_ok = (ext_bit == in_addr[63]);

  assign sx56 = {{7{in_addr[56]}}, in_addr[56:0]};
  assign sx47 = {{16{in_addr[47]}}, in_addr[47:0]};

  assign full_ok = la57_en ? ((&in_addr[63:56]) | ~(|in_addr[63:56]))
                           : ((&in_addr[63:47]) | ~(|in_addr[63:47]));

  assign gp    = mask_on ? ~relaxed_ok : ~full_ok;
  assign clean = (mask_on & relaxed_ok) ? (from56 ? sx56 : sx47) : in_addr;

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_gp    <= 1'b0;
      out_orig  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= clean;
        out_gp   <= gp;
        out_orig <= in_addr;
      end
    end
  end

  assign rsv = cap_en ? (RSV_ALL & ~TAG_EXEMPT) : RSV_ALL;
  assign base_chk_fault = lma_en & (|(base_chk_data & rsv));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_gp) && $stable(out_orig));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_orig == $past(in_addr));

  p_gp_orig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_gp |-> out_addr == out_orig);

  p_sign_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[63] == out_orig[63]);

  p_low_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[47:0] == out_orig[47:0]);

  p_nolm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lma_en |-> !base_chk_fault);

  p_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/sim_ptr_tag_strip.sv
module sim_ptr_tag_strip;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [63:0] in_addr = '0, base_d = '0;
  logic cap = 1'b0, u57 = 1'b0, u48 = 1'b0, sup = 1'b0, l5 = 1'b0, lma = 1'b0;
  logic in_ready, out_valid, out_gp, bfault, bfault52;
  logic in_ready_b, out_valid_b, out_gp_b;
  logic [63:0] out_addr, out_orig, out_addr_b, out_orig_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptr_tag_strip #(.PA_BITS(46)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .cap_en(cap), .u57_en(u57), .u48_en(u48), .sup_en(sup), .la57_en(l5), .lma_en(lma),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_gp(out_gp),
    .out_orig(out_orig), .base_chk_data(base_d), .base_chk_fault(bfault));

  ptr_tag_strip #(.PA_BITS(52)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b), .in_addr(in_addr),
    .cap_en(cap), .u57_en(u57), .u48_en(u48), .sup_en(sup), .la57_en(l5), .lma_en(lma),
    .out_valid(out_valid_b), .out_ready(out_ready), .out_addr(out_addr_b), .out_gp(out_gp_b),
    .out_orig(out_orig_b), .base_chk_data(base_d), .base_chk_fault(bfault52));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input bit c, input bit m57, input bit m48,
                                input bit s, input bit f5, output logic [63:0] e, output bit g);
    int b, fb;
    bit on;
    logic [63:0] top;
    if (a[63]) begin on = c & s; b = f5 ? 56 : 47; end
    else begin on = c & (m57 | m48); b = (c & m57) ? 56 : 47; end
    fb = f5 ? 56 : 47;
    top = a >> fb;
    if (on) begin
      g = (a[63] != a[b]);
      e = g ? a : 64'($signed(a << (63 - b)) >>> (63 - b));
    end else begin
      g = !(top == 64'd0 || top == ((64'd1 << (64 - fb)) - 64'd1));
      e = a;
    end
  endfunction

  function automatic bit base_model(input logic [63:0] d, input bit c, input bit lm, input int pa);
    bit f = 1'b0;
    for (int i = pa; i < 64; i++)
      if (d[i] && !(c && (i == 61 || i == 62))) f = 1'b1;
    return lm & f;
  endfunction

  task automatic xfer(input string req, input logic [63:0] a, input bit c, input bit m57,
                      input bit m48, input bit s, input bit f5);
    logic [63:0] e;
    bit g;
    @(negedge clk);
    in_addr = a; cap = c; u57 = m57; u48 = m48; sup = s; l5 = f5; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    model(a, c, m57, m48, s, f5, e, g);
    chk(req, {63'd0, out_valid}, 64'd1);
    chk(req, out_addr, e);
    chk(req, {63'd0, out_gp}, {63'd0, g});
    chk("R11", out_orig, a);
    chk(req, out_addr_b, e);
  endtask

  task automatic t_reset;
    chk("R1", {63'd0, out_valid}, 64'd0);
    chk("R1", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_user57;
    xfer("R3", 64'h7E12_3456_789A_BCDE, 1, 1, 0, 0, 0);
    chk("R3", out_addr, 64'h0012_3456_789A_BCDE);
    xfer("R7", 64'h7F12_3456_789A_BCDE, 1, 1, 0, 0, 0);
    chk("R7", {63'd0, out_gp}, 64'd1);
  endtask

  task automatic t_user48;
    xfer("R4", 64'h5A5A_1234_5678_9ABC, 1, 0, 1, 0, 0);
    chk("R4", out_addr, 64'h0000_1234_5678_9ABC);
    xfer("R7", 64'h5A5A_8234_5678_9ABC, 1, 0, 1, 0, 0);
    chk("R7", out_addr, 64'h5A5A_8234_5678_9ABC);
  endtask

  task automatic t_prio;
    xfer("R5", 64'h4034_1234_5678_9ABC, 1, 1, 1, 0, 0);
    chk("R5", out_addr, 64'h0034_1234_5678_9ABC);
  endtask

  task automatic t_super;
    xfer("R6", 64'hABCD_F234_5678_9ABC, 1, 0, 0, 1, 0);
    chk("R6", out_addr, 64'hFFFF_F234_5678_9ABC);
    xfer("R6", 64'h8123_4567_89AB_CDEF, 1, 0, 0, 1, 1);
    chk("R6", out_addr, 64'hFF23_4567_89AB_CDEF);
    xfer("R7", 64'hABCD_7234_5678_9ABC, 1, 0, 0, 1, 0);
    chk("R7", {63'd0, out_gp}, 64'd1);
    xfer("R6", 64'hABCD_F234_5678_9ABC, 1, 1, 1, 0, 0);
    chk("R6", {63'd0, out_gp}, 64'd1);
  endtask

  task automatic t_plain;
    xfer("R8", 64'hFFFF_8000_0000_1000, 0, 0, 0, 0, 0);
    chk("R8", {63'd0, out_gp}, 64'd0);
    xfer("R8", 64'h0001_0000_0000_0000, 1, 0, 0, 0, 0);
    chk("R8", {63'd0, out_gp}, 64'd1);
    xfer("R8", 64'h0001_0000_0000_0000, 1, 0, 0, 0, 1);
    chk("R8", {63'd0, out_gp}, 64'd0);
    xfer("R9", 64'h7E12_3456_789A_BCDE, 0, 1, 1, 1, 0);
    chk("R9", {63'd0, out_gp}, 64'd1);
  endtask

  task automatic t_sweep;
    logic [63:0] pats [8];
    pats[0] = 64'h7E12_3456_789A_BCDE; pats[1] = 64'h7F12_3456_789A_BCDE;
    pats[2] = 64'h5A5A_8234_5678_9ABC; pats[3] = 64'hABCD_F234_5678_9ABC;
    pats[4] = 64'h8123_4567_89AB_CDEF; pats[5] = 64'hFFFF_FFFF_FFFF_F000;
    pats[6] = 64'h0000_7FFF_FFFF_F000; pats[7] = 64'h80FE_0000_0000_0040;
    for (int m = 0; m < 32; m++)
      for (int p = 0; p < 8; p++)
        xfer("R8", pats[p], m[0], m[1], m[2], m[3], m[4]);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = 64'h7E12_3456_789A_BCDE; cap = 1; u57 = 1; u48 = 0; sup = 0; l5 = 0;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_addr = 64'h0000_0000_0000_0AAA;
    @(negedge clk);
    chk("R2", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    chk("R2", out_addr, 64'h0012_3456_789A_BCDE);
    chk("R2", out_orig, 64'h7E12_3456_789A_BCDE);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R2", out_orig, 64'h0000_0000_0000_0AAA);
    @(negedge clk);
    chk("R2", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic bcase(input logic [63:0] d, input bit c, input bit lm);
    @(negedge clk);
    base_d = d; cap = c; lma = lm;
    #1;
    chk("R10", {63'd0, bfault}, {63'd0, base_model(d, c, lm, 46)});
    chk("R10", {63'd0, bfault52}, {63'd0, base_model(d, c, lm, 52)});
  endtask

  task automatic t_base;
    bcase(64'h4000_0000_0000_1000, 1, 1);
    bcase(64'h0000_4000_0000_0000, 1, 1);
    bcase(64'h0000_2000_0000_0000, 1, 1);
    bcase(64'h2000_0000_0000_0000, 0, 1);
    bcase(64'h0010_0000_0000_0000, 1, 1);
    bcase(64'h0008_0000_0000_0000, 1, 1);
    bcase(64'h8000_0000_0000_0000, 1, 0);
    bcase(64'h8000_0000_0000_0000, 1, 1);
    chk("R10", {63'd0, bfault}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user57();
    t_user48();
    t_prio();
    t_super();
    t_plain();
    t_stall();
    t_sweep();
    t_base();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule